// File: doc/BRIEF.md
# Half-Rate Sync Divider with Pass-Through

This block sits on the path of a periodic sync pulse train. It drives an output pin with one of two signals. The first is a square wave at half the input rate, with equal high and low times. The second is a copy of the input, and the copy can be inverted. The input is asynchronous to the block clock, so it first passes through a flop synchronizer. All decisions are made on the synchronized level.

Three active-low-style control bits are registered on every clock edge:
- The ownership bit decides whether the pin carries this signal or is left to general-purpose port logic. The block reports the choice on a select output.
- The pass-through bit picks copy mode over divide mode.
- The polarity bit picks the sense of the copy.

Reset loads all three control registers to 1. The pin therefore starts out released, in divide mode, with positive polarity.

Top module: `hfd_half_rate`

## Requirements
- R1: `pin_own` is 1 exactly when the `en_n` value captured at the previous clock edge was 0. A change on `en_n` shows on `pin_own` after the next rising clock edge.
- R2: In divide mode (`thru_n` captured as 1, pin owned), `pin_out` toggles once for every rising edge of the synchronized input. For an input of period H+L cycles, every high run and every low run of `pin_out` lasts H+L cycles.
- R3: In pass-through mode (`thru_n` captured as 0) with `pol_pos` captured as 1, `pin_out` equals the value `sig_in` had two clock edges earlier.
- R4: In pass-through mode with `pol_pos` captured as 0, `pin_out` is the inverse of the value `sig_in` had two clock edges earlier.
- R5: During reset, and after reset until the first clock edge that samples the control inputs, `pin_own` and `pin_out` are 0. This holds whatever the control inputs are, because the control registers reset to 1.
- R6: The divider state is cleared to 0 on every edge at which the block is disabled. After re-enabling, the first input rise driven before clock edge i makes `pin_out` go to 1 after edge i+2, in divide mode.
- R7: `pin_out` is 0 whenever `pin_own` is 0.
- R8: `pol_pos` has no effect on `pin_out` in divide mode.
- R9: The synchronizer has `SYNC_STAGES` flops (default 2). The synchronized level equals the input delayed by that many edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Asynchronous sync pulse input |
| en_n | input | 1 | 0 gives the pin to this block, 1 leaves it to port logic |
| thru_n | input | 1 | 0 selects pass-through, 1 selects divide-by-two |
| pol_pos | input | 1 | Pass-through sense: 1 positive (copy), 0 negative (inverted) |
| pin_out | output | 1 | Value driven onto the pin when owned |
| pin_own | output | 1 | 1 when the pin carries this block's signal |

## Verification
The hardest situation to reach is the divider phase after a disable and re-enable. Its output depends on a cleared flop and on the exact edge at which the first synchronized rise is seen. The stimulus holds the input low, disables the block for two cycles, and enables it again. It then raises the input at a known negative edge and expects the output to be low, low, and then high on the following cycles. A sweep over high and low times of one to four cycles, including single-cycle pulses, checks the run lengths of the halved wave under both polarity settings.

// File: rtl/hfd_pkg.sv
package hfd_pkg;
  typedef struct packed {
    logic en_n;
    logic thru_n;
    logic pol_pos;
  } hfd_ctrl_t;

  localparam hfd_ctrl_t HFD_CTRL_RST = '{en_n: 1'b1, thru_n: 1'b1, pol_pos: 1'b1};
endpackage

// File: rtl/hfd_sync.sv
module hfd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[LAST-1:0], d};
      end
    end
  endgenerate

  assign q = sr[LAST];

  // R9: output follows the input one edge per stage later
  a_r9_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> q == $past(sr[(LAST > 0) ? LAST-1 : 0]) || (STAGES == 1 && q == $past(d)));
endmodule

// File: rtl/hfd_div.sv
module hfd_div (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic clr,
  output logic q
);
  logic prev;
  logic rise;

  assign rise = lvl & ~prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      q    <= 1'b0;
    end else begin
      prev <= lvl;
      if (clr)       q <= 1'b0;
      else if (rise) q <= ~q;
    end
  end

  // R2: one toggle per synchronized rising edge
  a_r2_toggle_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && lvl && !prev) |=> q != $past(q));
  // R2: no toggle without a rising edge
  a_r2_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(lvl && !prev)) |=> $stable(q));
  // R6: disabled means cleared
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !q);
endmodule

// File: rtl/hfd_half_rate.sv
module hfd_half_rate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  input  logic en_n,
  input  logic thru_n,
  input  logic pol_pos,
  output logic pin_out,
  output logic pin_own
);
  import hfd_pkg::*;

  hfd_ctrl_t ctrl_q;
  logic      lvl;
  logic      div_q;
  logic      copy_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= HFD_CTRL_RST;
    else        ctrl_q <= '{en_n: en_n, thru_n: thru_n, pol_pos: pol_pos};
  end

  hfd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (sig_in),
    .q    (lvl)
  );

  hfd_div u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (lvl),
    .clr  (ctrl_q.en_n),
    .q    (div_q)
  );

  assign copy_v  = ctrl_q.pol_pos ? lvl : ~lvl;
  assign pin_own = ~ctrl_q.en_n;
  assign pin_out = pin_own & (ctrl_q.thru_n ? div_q : copy_v);

  // R1: ownership follows the sampled enable
  a_r1_own_on: assert property (@(posedge clk) disable iff (!rst_n)
    !en_n |=> pin_own);
  a_r1_own_off: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> !pin_own);
  // R7: released pin is quiet
  a_r7_quiet_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_own |-> !pin_out);
  // R4: negative sense inverts the synchronized level
  a_r4_inverted_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !thru_n && !pol_pos) |=> pin_out != lvl);
  // R3: positive sense copies the synchronized level
  a_r3_plain_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !thru_n && pol_pos) |=> pin_out == lvl);
endmodule

// File: tb/sim_hfd_half_rate.sv
`timescale 1ns/1ps
module sim_hfd_half_rate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig_in = 1'b0;
  logic en_n = 1'b0;
  logic thru_n = 1'b0;
  logic pol_pos = 1'b0;
  logic pin_out, pin_own;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // bench reference state
  logic m_h1 = 0, m_h2 = 0, m_h3 = 0, m_enp = 1, m_div = 0;
  // run-length monitor
  bit   mon_on = 0;
  logic mon_last = 0;
  int   mon_run = 0, mon_seen = 0, mon_want = 0;

  always #2.5 clk = ~clk;

  hfd_half_rate u0 (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .en_n(en_n),
    .thru_n(thru_n), .pol_pos(pol_pos), .pin_out(pin_out), .pin_own(pin_own)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input logic in, input logic en, input logic th, input logic po);
    logic eo, ev;
    string tg;
    @(negedge clk);
    sig_in = in; en_n = en; thru_n = th; pol_pos = po;
    @(posedge clk);
    #1;
    if (m_enp) m_div = 1'b0;
    else if (m_h2 && !m_h3) m_div = ~m_div;
    m_h3 = m_h2; m_h2 = m_h1; m_h1 = in; m_enp = en;
    eo = ~en;
    ev = eo ? (!th ? (po ? m_h2 : ~m_h2) : m_div) : 1'b0;
    if (!eo)     tg = "R7";
    else if (!th) tg = po ? "R3" : "R4";
    else          tg = po ? "R2" : "R8";
    chk("R1", pin_own, eo);
    chk(tg, pin_out, ev);
    if (mon_on) begin
      if (pin_out !== mon_last) begin
        if (mon_seen >= 1) chk("R2", (mon_run == mon_want), 1'b1);
        mon_seen++;
        mon_run = 1;
        mon_last = pin_out;
      end else begin
        mon_run++;
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R5: controls asserted low during reset must not take effect
    repeat (3) @(posedge clk);
    #1;
    chk("R5", pin_own, 1'b0);
    chk("R5", pin_out, 1'b0);
    @(negedge clk);
    en_n = 1; thru_n = 1; pol_pos = 1; sig_in = 0;
    rst_n = 1'b1;
    #1;
    chk("R5", pin_own, 1'b0);
    chk("R5", pin_out, 1'b0);

    // pass-through sweep, both polarities (R3, R4, R9)
    for (int po = 0; po < 2; po++) begin
      for (int h = 1; h <= 3; h++) begin
        for (int l = 1; l <= 3; l++) begin
          for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < h + l; c++) tick(c < h, 1'b0, 1'b0, po[0]);
          end
        end
      end
    end

    // divide sweep with run-length check (R2, R8)
    for (int po = 0; po < 2; po++) begin
      for (int h = 1; h <= 4; h++) begin
        for (int l = 1; l <= 4; l++) begin
          mon_on = 0;
          tick(1'b0, 1'b1, 1'b1, po[0]);
          tick(1'b0, 1'b1, 1'b1, po[0]);
          mon_want = h + l;
          mon_seen = 0; mon_run = 0; mon_last = 1'b0;
          mon_on = 1;
          for (int p = 0; p < 6; p++) begin
            for (int c = 0; c < h + l; c++) tick(c < h, 1'b0, 1'b1, po[0]);
          end
          mon_on = 0;
          chk("R2", (mon_seen >= 5), 1'b1);
        end
      end
    end

    // R6: clear on disable, then known phase after re-enable
    tick(1'b1, 1'b0, 1'b1, 1'b1);
    tick(1'b0, 1'b1, 1'b1, 1'b1);
    tick(1'b0, 1'b1, 1'b1, 1'b1);
    tick(1'b0, 1'b0, 1'b1, 1'b1);
    tick(1'b0, 1'b0, 1'b1, 1'b1);
    tick(1'b0, 1'b0, 1'b1, 1'b1);
    tick(1'b1, 1'b0, 1'b1, 1'b1);
    chk("R6", pin_out, 1'b0);
    tick(1'b1, 1'b0, 1'b1, 1'b1);
    chk("R6", pin_out, 1'b0);
    tick(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R6", pin_out, 1'b1);
    tick(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R6", pin_out, 1'b1);

    // R7: releasing the pin while the input keeps toggling
    for (int c = 0; c < 12; c++) tick(c[1], 1'b1, c[2], c[0]);
    chk("R7", pin_out, 1'b0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule